// File: doc/BRIEF.md
# Trigger-Gated External Event Counter

This block counts rising edges of an asynchronous external event pin. The count starts only after a qualified edge on a separate trigger pin. Both pins are brought into the system clock domain by a two-flop synchronizer, followed by a one-cycle edge detector. An event edge therefore reaches the counter three system-clock cycles after it appears at the pin. A trigger edge takes the same three cycles to set the run bit.

A trigger edge is qualified only when two conditions hold:
- the trigger-source field selects the trigger pin;
- the edge matches the selected polarity.

A qualified trigger always raises a sticky trigger flag. It also sets the run bit when the operating-mode field selects trigger mode. From then on every synchronized rising edge of the event pin adds one to a 16-bit count.

Software reaches everything through a simple register port, with a write strobe, a two-bit address and combinational read data. The register map is:
- 0 CONTROL: bit 0 run, bit 1 freeze-on-halt, bit 2 trigger-on-falling.
- 1 MODE: bits 2:0 operating mode, bits 6:4 trigger source.
- 2 STATUS: bit 0 trigger flag.
- 3 COUNT.

A debug-halt input stops the count while the freeze bit is set.

Top module: `trig_gated_counter`

## Requirements
- R1: After reset all four registers read 0; unused read bits are always 0.
- R2: With MODE = 0x56 (mode 3'b110 in bits 2:0, source 3'b101 in bits 6:4), a qualified trigger edge sets CONTROL bit 0 and STATUS bit 0. Both become visible after the third rising clock edge following the pin change, and not after the second.
- R3: With source 3'b101 and a mode other than 3'b110, a trigger edge sets only STATUS bit 0. With a source other than 3'b101, a trigger edge sets neither bit.
- R4: When CONTROL bit 2 is 0, only rising trigger edges qualify. When it is 1, only falling trigger edges qualify.
- R5: While CONTROL bit 0 is 1, COUNT increases by one for each rising edge of the event pin, after the third clock edge following the pin change. It never increases on the system clock alone.
- R6: Event-pin edges have no effect on COUNT while CONTROL bit 0 is 0.
- R7: COUNT wraps from 0xFFFF to 0x0000.
- R8: STATUS bit 0 stays set until software writes 0 to it. Writing 1 has no effect. A flag set in the same cycle as a clearing write wins.
- R9: While the debug-halt input is 1 and CONTROL bit 1 is 1, COUNT holds. With CONTROL bit 1 at 0, the halt input has no effect.
- R10: Writing 0 to CONTROL bit 0 stops counting, and a later qualified trigger edge restarts it. A trigger edge while already running sets only the flag. A trigger edge in the same cycle as a software write to CONTROL takes precedence for bit 0.
- R11: Writing COUNT loads the written value, overriding an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigPin | input | 1 | Asynchronous trigger pin |
| eventPin | input | 1 | Asynchronous external event pin |
| dbgHalt | input | 1 | Debug-halt request, synchronous to clk |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr, combinational |

## Verification
The bench targets three kinds of corner case.

- **Latency.** It samples the run bit and the count after the second and the third clock edges following a pin change. A synchronizer with one stage too many or too few shows up as a cycle of error.
- **Gating.** It drives event pulses before any trigger, after software stops the counter, and during a freeze-enabled debug halt. A design that gates on the wrong condition keeps counting in one of these windows.
- **Qualification and control.** It walks the mode, source and polarity mismatches, checks that the flag is sticky against a write of 1, and preloads near 0xFFFF. A decoder that ignores a field, a flag that clears on any write, or a counter that saturates each produce a wrong readback.

// File: rtl/trig_counter_pkg.sv
package trig_counter_pkg;
  localparam int CNT_W       = 16;
  localparam int ADDR_W      = 2;
  localparam int SYNC_STAGES = 2;
  localparam logic [2:0] MODE_TRIGGER = 3'b110;
  localparam logic [2:0] SRC_TRIGPIN  = 3'b101;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd3;

  typedef struct packed {
    logic inc;
    logic load;
  } cntStrobe_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic detectFall,
  output logic edgeHit
);
  logic [STAGES-1:0] chain;
  logic prevLevel;
  logic syncLevel;

  assign syncLevel = chain[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '0;
      prevLevel <= 1'b0;
    end else begin
      chain     <= {chain[STAGES-2:0], pinIn};
      prevLevel <= syncLevel;
    end
  end

  assign edgeHit = detectFall ? (prevLevel & ~syncLevel) : (syncLevel & ~prevLevel);
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigPin,
  input  logic              eventPin,
  input  logic              dbgHalt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output cntStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadVal,
  output logic              runBit,
  output logic              freezeBit,
  output logic              fallBit,
  output logic [2:0]        slaveMode,
  output logic [2:0]        trigSrc,
  output logic              trigFlag
);
  logic trigEdge, eventRise;
  logic flagSet, runSet;
  logic wrCtrl, wrMode, wrStatus;

  edge_sync #(.STAGES(SYNC_STAGES)) i_trigSync (
    .clk(clk), .rstN(rstN), .pinIn(trigPin), .detectFall(fallBit), .edgeHit(trigEdge));

  edge_sync #(.STAGES(SYNC_STAGES)) i_eventSync (
    .clk(clk), .rstN(rstN), .pinIn(eventPin), .detectFall(1'b0), .edgeHit(eventRise));

  assign wrCtrl   = wrEn && (addr == ADDR_CTRL);
  assign wrMode   = wrEn && (addr == ADDR_MODE);
  assign wrStatus = wrEn && (addr == ADDR_STATUS);

  assign flagSet = trigEdge && (trigSrc == SRC_TRIGPIN);
  assign runSet  = flagSet && (slaveMode == MODE_TRIGGER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      freezeBit <= 1'b0;
      fallBit   <= 1'b0;
      slaveMode <= 3'd0;
      trigSrc   <= 3'd0;
      trigFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        freezeBit <= wrData[1];
        fallBit   <= wrData[2];
      end
      if (runSet)      runBit <= 1'b1;
      else if (wrCtrl) runBit <= wrData[0];
      if (wrMode) begin
        slaveMode <= wrData[2:0];
        trigSrc   <= wrData[6:4];
      end
      if (flagSet)                    trigFlag <= 1'b1;
      else if (wrStatus && !wrData[0]) trigFlag <= 1'b0;
    end
  end

  assign strobe.load = wrEn && (addr == ADDR_COUNT);
  assign strobe.inc  = eventRise && runBit && !(dbgHalt && freezeBit);
  assign loadVal     = wrData;
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_counter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntValue
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntValue <= '0;
    else if (strobe.load) cntValue <= loadVal;
    else if (strobe.inc)  cntValue <= cntValue + 1'b1;
  end
endmodule

// File: rtl/trig_gated_counter.sv
module trig_gated_counter
  import trig_counter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigPin,
  input  logic              eventPin,
  input  logic              dbgHalt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData
);
  cntStrobe_t       strobe;
  logic [CNT_W-1:0] loadVal, cntValue;
  logic             runBit, freezeBit, fallBit, trigFlag;
  logic [2:0]       slaveMode, trigSrc;

  trig_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .eventPin(eventPin), .dbgHalt(dbgHalt),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .strobe(strobe), .loadVal(loadVal),
    .runBit(runBit), .freezeBit(freezeBit), .fallBit(fallBit), .slaveMode(slaveMode),
    .trigSrc(trigSrc), .trigFlag(trigFlag));

  trig_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal), .cntValue(cntValue));

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_CTRL:   rdData[2:0] = {fallBit, freezeBit, runBit};
      ADDR_MODE:   rdData[6:0] = {trigSrc, 1'b0, slaveMode};
      ADDR_STATUS: rdData[0]   = trigFlag;
      default:     rdData      = cntValue;
    endcase
  end
endmodule

// File: rtl/trig_gated_counter_chk.sv
module trig_gated_counter_chk
  import trig_counter_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dbgHalt,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  cntValue,
  input logic              runBit,
  input logic              freezeBit,
  input logic              trigFlag
);
  logic cntWrite;
  assign cntWrite = wrEn && (addr == ADDR_COUNT);

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (cntValue == $past(cntValue)) || (cntValue == $past(cntValue) + 16'd1));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !cntWrite) |=> $stable(cntValue));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && dbgHalt && freezeBit && !cntWrite) |=> $stable(cntValue));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigFlag && !(wrEn && addr == ADDR_STATUS && !wrData[0])) |=> trigFlag);
endmodule

bind trig_gated_counter trig_gated_counter_chk i_chk (
  .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cntValue(cntValue), .runBit(runBit), .freezeBit(freezeBit), .trigFlag(trigFlag));

// File: tb/test_trig_gated_counter.sv
`timescale 1ns/1ps
module test_trig_gated_counter;
  logic clk = 1'b0, rstN = 1'b0, trigPin = 1'b0, eventPin = 1'b0, dbgHalt = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wrData = 16'd0, rdData, val;
  int testsRun = 0, testsFailed = 0, cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  trig_gated_counter i_trig_gated_counter (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .eventPin(eventPin), .dbgHalt(dbgHalt),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData));

  // {start[15:0], pulses[7:0], freeze, halt, expected[15:0]}
  localparam logic [41:0] VEC [6] = '{
    {16'd0,     8'd5, 1'b0, 1'b0, 16'd5},
    {16'hFFFD,  8'd5, 1'b0, 1'b0, 16'd2},
    {16'd100,   8'd3, 1'b1, 1'b1, 16'd100},
    {16'd100,   8'd3, 1'b0, 1'b1, 16'd103},
    {16'd7,     8'd0, 1'b0, 1'b0, 16'd7},
    {16'hFFFF,  8'd1, 1'b0, 1'b0, 16'd0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic setTrig(input logic v);
    @(negedge clk); trigPin = v;
    repeat (5) @(posedge clk);
  endtask

  task automatic eventPulse();
    @(negedge clk); eventPin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); eventPin = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(a[1:0], val); check("R1 reset readback", val, 16'd0);
    end

    regWrite(2'd1, 16'h0056);
    // R6 events before trigger are ignored
    repeat (3) eventPulse();
    regRead(2'd3, val); check("R6 count before trigger", val, 16'd0);
    regRead(2'd0, val); check("R6 run bit before trigger", val, 16'd0);

    // R2 trigger latency
    @(negedge clk); trigPin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 2'd0; #1 check("R2 run not set after two edges", rdData, 16'd0);
    @(posedge clk);
    @(negedge clk); addr = 2'd0; #1 check("R2 run set after third edge", rdData, 16'd1);
    regRead(2'd2, val); check("R2 flag set", val, 16'd1);

    // R8 sticky flag
    regWrite(2'd2, 16'd1);
    regRead(2'd2, val); check("R8 write 1 keeps flag", val, 16'd1);
    regWrite(2'd2, 16'd0);
    regRead(2'd2, val); check("R8 write 0 clears flag", val, 16'd0);

    // R5 event latency
    @(negedge clk); eventPin = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 2'd3; #1 check("R5 no count after two edges", rdData, 16'd0);
    @(posedge clk);
    @(negedge clk); addr = 2'd3; #1 check("R5 count after third edge", rdData, 16'd1);
    @(negedge clk); eventPin = 1'b0;
    repeat (20) @(posedge clk);
    regRead(2'd3, val); check("R5 no count on system clock", val, 16'd1);

    // R10 retrigger while running sets only the flag
    setTrig(1'b0); setTrig(1'b1);
    regRead(2'd2, val); check("R10 retrigger flag", val, 16'd1);
    regRead(2'd3, val); check("R10 retrigger count unchanged", val, 16'd1);
    regRead(2'd0, val); check("R10 retrigger run unchanged", val, 16'd1);
    regWrite(2'd2, 16'd0);

    // R10 software stop then restart by trigger
    regWrite(2'd0, 16'd0);
    eventPulse();
    regRead(2'd3, val); check("R10 stopped count holds", val, 16'd1);
    setTrig(1'b0); setTrig(1'b1);
    eventPulse();
    regRead(2'd3, val); check("R10 restarted count", val, 16'd2);

    // R3 mode mismatch: flag only
    regWrite(2'd0, 16'd0); regWrite(2'd2, 16'd0); regWrite(2'd1, 16'h0055);
    setTrig(1'b0); setTrig(1'b1);
    regRead(2'd2, val); check("R3 other mode sets flag", val, 16'd1);
    regRead(2'd0, val); check("R3 other mode leaves run clear", val, 16'd0);
    // R3 source mismatch: nothing
    regWrite(2'd2, 16'd0); regWrite(2'd1, 16'h0046);
    setTrig(1'b0); setTrig(1'b1);
    regRead(2'd2, val); check("R3 other source no flag", val, 16'd0);
    regRead(2'd0, val); check("R3 other source no run", val, 16'd0);

    // R4 polarity
    regWrite(2'd1, 16'h0056);
    setTrig(1'b0);
    regWrite(2'd2, 16'd0);
    regWrite(2'd0, 16'h0004);
    setTrig(1'b1);
    regRead(2'd0, val); check("R4 rising ignored when falling selected", val, 16'h0004);
    regRead(2'd2, val); check("R4 no flag on rising", val, 16'd0);
    setTrig(1'b0);
    regRead(2'd0, val); check("R4 falling edge starts run", val, 16'h0005);
    regRead(2'd2, val); check("R4 flag on falling", val, 16'd1);

    // R11 load, R7 wrap, R9 halt: table walk
    foreach (VEC[i]) begin
      regWrite(2'd3, VEC[i][41:26]);
      regRead(2'd3, val); check("R11 count load", val, VEC[i][41:26]);
      regWrite(2'd0, {14'd0, VEC[i][17], 1'b1});
      @(negedge clk); dbgHalt = VEC[i][16];
      for (int p = 0; p < int'(VEC[i][25:18]); p++) eventPulse();
      repeat (4) @(posedge clk);
      regRead(2'd3, val);
      check($sformatf("R5 R7 R9 table row %0d", i), val, VEC[i][15:0]);
      @(negedge clk); dbgHalt = 1'b0;
    end

    finish();
  end
endmodule